// File: doc/BRIEF.md
# Locally Decoded Integer ALU

This block is a 32-bit integer arithmetic unit that carries its own small operation decoder. The main instruction decoder sends only a 2-bit operation class. The block also receives the 6-bit function field of the instruction. It turns the two into a 3-bit operation code and applies that operation to two operands. The operations are bitwise AND, bitwise OR, add, subtract and signed set-on-less-than.

It drives the result, a flag that is high when the result is all zeros, and the 3-bit code it chose. A branch-on-equal uses the subtract class and reads the zero flag. Loads and stores use the add class to form an address. Register-to-register instructions use the function field.

The block is purely combinational. Every output settles from the present inputs, with no clock and no storage.

Top module: `dec_alu`

## Requirements
- R1: `alu_op` uses these codes: 000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than. `result` is the matching operation on `a` and `b`.
- R2: Class 00 selects add (`alu_op` = 010), whatever the function field holds.
- R3: Any class whose LSB is 1 (01 or 11) selects subtract (`alu_op` = 110), whatever the function field holds.
- R4: Class 10 decodes the function field as follows: 100000 add, 100010 subtract, 100100 AND, 100101 OR, 101010 set-on-less-than.
- R5: Under class 10, function bits 5 and 4 are ignored. Only bits 3:0 choose the operation.
- R6: Add and subtract wrap modulo 2^32, with no overflow indication.
- R7: Set-on-less-than returns 1 when `a` < `b` as two's-complement signed numbers, and 0 otherwise. Bits 31:1 are zero.
- R8: `zero` is 1 exactly when all 32 bits of `result` are 0.
- R9: All outputs follow the inputs within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the instruction |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| alu_op | output | 3 | Decoded operation code |

## Verification
Two functions can land in the same cycle: the subtract that the branch class forces, and the zero flag that the branch condition reads. The bench provokes this with the branch class on equal operands and on unequal operands. It also provokes it with class 11, to show that the class LSB alone forces the subtract. In each case it judges the code, the difference and the flag together against an independent model. A signed compare that is false, and an add that wraps to zero, also raise the flag in the same cycle as their result, and are judged the same way.

// File: rtl/alu_dec_pkg.sv
`timescale 1ns/1ps
package alu_dec_pkg;
  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_AND = 3'b000;
  localparam logic [OP_W-1:0] OP_OR  = 3'b001;
  localparam logic [OP_W-1:0] OP_ADD = 3'b010;
  localparam logic [OP_W-1:0] OP_SUB = 3'b110;
  localparam logic [OP_W-1:0] OP_SLT = 3'b111;

  // low nibble of the function field; bits 5:4 are not decoded
  localparam logic [3:0] FN_ADD = 4'b0000;
  localparam logic [3:0] FN_SUB = 4'b0010;
  localparam logic [3:0] FN_AND = 4'b0100;
  localparam logic [3:0] FN_OR  = 4'b0101;
  localparam logic [3:0] FN_SLT = 4'b1010;
endpackage

// File: rtl/alu_op_dec.sv
`timescale 1ns/1ps
module alu_op_dec
  import alu_dec_pkg::*;
#(
  parameter int unsigned CLS_W = 2,
  parameter int unsigned FN_W  = 6
) (
  input  logic [CLS_W-1:0] op_class,
  input  logic [FN_W-1:0]  funct,
  output logic [OP_W-1:0]  op
);
  localparam int unsigned FN_KEY_W = 4;

  logic [FN_KEY_W-1:0] fn_key;
  logic [FN_W-FN_KEY_W-1:0] unused_fn_hi;

  assign fn_key       = funct[FN_KEY_W-1:0];
  assign unused_fn_hi = funct[FN_W-1:FN_KEY_W];

  logic [OP_W-1:0] fn_op;

  always_comb begin
    unique case (fn_key)
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_SLT:  fn_op = OP_SLT;
      default: fn_op = OP_ADD;
    endcase
  end

  // class LSB has priority: a forced subtract wins over the function field
  always_comb begin
    if (op_class[0])      op = OP_SUB;
    else if (op_class[1]) op = fn_op;
    else                  op = OP_ADD;
  end

  always_comb begin
    if (!$isunknown(op_class) && !$isunknown(funct)) begin
      p_mem_class_add_r2: assert (op_class != 2'b00 || op == OP_ADD)
        else $error("class 00 did not give add");
      p_fn_subset_r4: assert (op_class != 2'b10 || op inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT})
        else $error("function decode gave unused code");
    end
  end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_dec_pkg::*;
#(
  parameter int unsigned W            = 32,
  parameter bit          SHARED_ADDER = 1'b1
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum;
  logic [W-1:0] diff;

  generate
    if (SHARED_ADDER) begin : g_shared
      // one carry chain: invert b and inject carry when op[2] is set
      logic [W-1:0] b_eff;
      logic [W-1:0] chain;
      assign b_eff = op[2] ? ~b : b;
      assign chain = a + b_eff + {{(W-1){1'b0}}, op[2]};
      assign sum   = chain;
      assign diff  = chain;
    end else begin : g_split
      assign sum  = a + b;
      assign diff = a - b;
    end
  endgenerate

  logic less;
  assign less = (a[MSB] != b[MSB]) ? a[MSB] : diff[MSB];

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_ADD:  y = sum;
      OP_SUB:  y = diff;
      OP_SLT:  y = {{(W-1){1'b0}}, less};
      default: y = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(op) && !$isunknown(a) && !$isunknown(b)) begin
      p_sub_inverse_r6: assert (op != OP_SUB || (y + b) == a)
        else $error("difference plus b differs from a");
      p_slt_bool_r7: assert (op != OP_SLT || y[W-1:1] == '0)
        else $error("compare result not boolean");
      p_and_subset_r1: assert (op != OP_AND || ((y & ~a) == '0 && (y & ~b) == '0))
        else $error("AND result has bit outside operands");
    end
  end
endmodule

// File: rtl/zero_detect.sv
`timescale 1ns/1ps
module zero_detect #(
  parameter int unsigned W     = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  localparam int unsigned NCHUNK = (W + CHUNK - 1) / CHUNK;
  localparam int unsigned PAD_W  = NCHUNK * CHUNK;

  logic [PAD_W-1:0]  padded;
  logic [NCHUNK-1:0] chunk_any;

  always_comb begin
    padded          = '0;
    padded[W-1:0]   = val;
  end

  generate
    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
      assign chunk_any[i] = |padded[i*CHUNK +: CHUNK];
    end
  endgenerate

  assign is_zero = ~|chunk_any;
endmodule

// File: rtl/dec_alu.sv
`timescale 1ns/1ps
module dec_alu
  import alu_dec_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned CLS_W = 2,
  parameter int unsigned FN_W  = 6
) (
  input  logic [CLS_W-1:0] op_class,
  input  logic [FN_W-1:0]  funct,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     result,
  output logic             zero,
  output logic [OP_W-1:0]  alu_op
);
  logic [OP_W-1:0] op_w;
  logic [W-1:0]    y_w;
  logic            z_w;

  alu_op_dec #(.CLS_W(CLS_W), .FN_W(FN_W)) u_dec (
    .op_class (op_class),
    .funct    (funct),
    .op       (op_w)
  );

  alu_core #(.W(W), .SHARED_ADDER(1'b1)) u_core (
    .op (op_w),
    .a  (a),
    .b  (b),
    .y  (y_w)
  );

  zero_detect #(.W(W), .CHUNK(8)) u_zero (
    .val     (y_w),
    .is_zero (z_w)
  );

  assign alu_op = op_w;
  assign result = y_w;
  assign zero   = z_w;

  always_comb begin
    if (!$isunknown(y_w) && !$isunknown(z_w)) begin
      p_zero_flag_r8: assert (z_w == (y_w == '0))
        else $error("zero flag disagrees with result");
    end
    if (!$isunknown(op_class)) begin
      p_lsb_forces_sub_r3: assert (!op_class[0] || op_w == OP_SUB)
        else $error("class LSB did not force subtract");
    end
  end
endmodule

// File: tb/sim_dec_alu.sv
`timescale 1ns/1ps
module sim_dec_alu;
  localparam int W = 32;

  logic clk;
  logic rst_n;
  logic [1:0]   op_class;
  logic [5:0]   funct;
  logic [W-1:0] a, b;
  logic [W-1:0] result;
  logic         zero;
  logic [2:0]   alu_op;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         z;
    logic [2:0]   op;
    string        tag;
  } item_t;

  item_t q[$];

  dec_alu u0 (
    .op_class (op_class),
    .funct    (funct),
    .a        (a),
    .b        (b),
    .result   (result),
    .zero     (zero),
    .alu_op   (alu_op)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model written from the requirements
  function automatic item_t model(input logic [1:0] c, input logic [5:0] f,
                                  input logic [W-1:0] x, input logic [W-1:0] y);
    item_t it;
    logic [2:0] o;
    if (c == 2'b01 || c == 2'b11) o = 3'b110;
    else if (c == 2'b00) o = 3'b010;
    else begin
      case (f[3:0])
        4'b0000: o = 3'b010;
        4'b0010: o = 3'b110;
        4'b0100: o = 3'b000;
        4'b0101: o = 3'b001;
        4'b1010: o = 3'b111;
        default: o = 3'b010;
      endcase
    end
    case (o)
      3'b000:  it.res = x & y;
      3'b001:  it.res = x | y;
      3'b010:  it.res = x + y;
      3'b110:  it.res = x - y;
      default: it.res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
    endcase
    it.op = o;
    it.z  = (it.res == 32'd0);
    return it;
  endfunction

  task automatic drive(input logic [1:0] c, input logic [5:0] f,
                       input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    op_class = c; funct = f; a = x; b = y;
    it = model(c, f, x, y);
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares at the falling edge, after the inputs settled
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res || zero !== e.z || alu_op !== e.op) begin
        errors++;
        $display("FAIL %s: got res=%h zero=%b op=%b, expected res=%h zero=%b op=%b",
                 e.tag, result, zero, alu_op, e.res, e.z, e.op);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_class = 2'b00; funct = 6'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give add of zeros
    drive(2'b00, 6'b000000, 32'h0, 32'h0, "R2 reset state");
    // R2: memory class adds, function field ignored
    drive(2'b00, 6'b100010, 32'd5, 32'd7, "R2 class00 with sub funct");
    drive(2'b00, 6'b101010, 32'h1000_0000, 32'h0000_0040, "R2 address add");
    // R3: branch class subtracts, equal and unequal operands with zero flag
    drive(2'b01, 6'b100000, 32'd9, 32'd9, "R3 branch equal");
    drive(2'b01, 6'b100100, 32'd9, 32'd4, "R3 branch unequal");
    drive(2'b11, 6'b100100, 32'd10, 32'd3, "R3 class11 forces sub");
    drive(2'b11, 6'b101010, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R3 class11 equal");
    // R4 / R1: each function code
    drive(2'b10, 6'b100000, 32'd100, 32'd23, "R4 funct add");
    drive(2'b10, 6'b100010, 32'd100, 32'd23, "R4 funct sub");
    drive(2'b10, 6'b100100, 32'hF0F0_1234, 32'h0FF0_FF00, "R1 funct and");
    drive(2'b10, 6'b100101, 32'hF000_0001, 32'h000F_0010, "R1 funct or");
    drive(2'b10, 6'b101010, 32'd3, 32'd8, "R4 funct slt");
    drive(2'b10, 6'b100100, 32'h5555_5555, 32'hAAAA_AAAA, "R1 and to zero");
    // R5: high function bits ignored
    drive(2'b10, 6'b110010, 32'd50, 32'd8, "R5 funct hi=11 sub");
    drive(2'b10, 6'b000100, 32'hFFFF_0000, 32'h00FF_FF00, "R5 funct hi=00 and");
    drive(2'b10, 6'b010101, 32'h0000_0003, 32'h0000_0300, "R5 funct hi=01 or");
    drive(2'b10, 6'b001010, 32'hFFFF_FFFF, 32'd0, "R5 funct hi=00 slt");
    // R6: wrap-around
    drive(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'd1, "R6 add wraps to zero");
    drive(2'b01, 6'b000000, 32'd0, 32'd1, "R6 sub wraps");
    drive(2'b00, 6'b000000, 32'h7FFF_FFFF, 32'd1, "R6 add past max positive");
    // R7: signed compare
    drive(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1, "R7 minus one less than one");
    drive(2'b10, 6'b101010, 32'd1, 32'hFFFF_FFFF, "R7 one not less than minus one");
    drive(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R7 min less than max");
    drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R7 max not less than min");
    drive(2'b10, 6'b101010, 32'd42, 32'd42, "R7 equal gives zero");
    // R8: zero flag low on nonzero result
    drive(2'b10, 6'b100101, 32'h0, 32'h8000_0000, "R8 msb only nonzero");
    // R9: back-to-back changes, each checked in its own cycle
    drive(2'b01, 6'b000000, 32'd7, 32'd7, "R9 step one");
    drive(2'b00, 6'b000000, 32'd7, 32'd7, "R9 step two");
    drive(2'b10, 6'b100100, 32'd7, 32'd0, "R9 step three");
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule